// File: doc/BRIEF.md
# Stereo Soft-Ramp Attenuation and Mute Controller

This block decides, for each of two audio channels, how much attenuation is applied to the signal at every sample frame. Configuration gives each channel a requested attenuation in whole decibels and a mute bit. A shared transition mode chooses how the applied level moves toward a new request: in one jump, in one jump held back until the waveform crosses zero, in a ramp of eighth-decibel steps, or in a ramp whose every step waits for a zero crossing. A link bit makes both channels obey channel A's request. The block computes no gain products. It only drives the applied attenuation, counted in eighth-dB units, which a downstream multiplier consumes.

The block works on a single-cycle frame strobe that comes with one signed 24-bit sample per channel. Mute is represented as a level one whole decibel past the deepest code, 760 eighths with the defaults. A muted channel therefore sits on the same ladder as every other level, and a soft-ramped mute walks that ladder. Auto-mute watches each channel for a long run of silent samples and forces the channel's target to mute. A combined mute-control output reports when both channels are fully muted.

Top module: `stereo_vol_ramp`

## Requirements
- R1: While rst_n is low, and on the first frame after it rises, level_a and level_b read 0 and mute_ctl reads 0.
- R2: With a requested code N of at most 94 and no mute source active, the target level is 8*N eighths. Code 0 maps to 0 and code 94 maps to 752.
- R3: A requested code above 94 is handled exactly like a set mute bit and gives a target of 760.
- R4: The outputs change only on the clock edge that samples frame_stb high. In mode 00 the level reaches its target on that same edge.
- R5: In mode 01 a differing target is applied in one jump, and only on a frame whose sample is a zero crossing. A zero crossing is a sample whose bit 23 differs from bit 23 of the channel's previous frame sample, or a sample that is exactly zero.
- R6: In mode 10 the level moves one eighth-dB toward the target on each frame and never by more.
- R7: In mode 11 the level moves one eighth-dB toward the target, and only on a zero-crossing frame.
- R8: In modes 01 and 11, a step that has been pending for 512 consecutive frames without a crossing is taken on the 512th of those frames.
- R9: With link set, channel B uses channel A's code and mute bit. Channel B's own code and mute bit have no effect.
- R10: With amute_en set, a channel whose last 8192 frame samples were all 0 or all ones (-1) targets mute from the next frame on. One sample of any other value clears this, and the clearing affects targets from the following frame.
- R11: mute_ctl is 1 exactly when both levels equal 760.
- R12: Zero-crossing detection, timeout counting and silence counting are kept separately for each channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per stereo frame |
| samp_a | input | 24 | Channel A sample, two's complement, valid with frame_stb |
| samp_b | input | 24 | Channel B sample, two's complement, valid with frame_stb |
| atten_a | input | 7 | Channel A requested attenuation in dB |
| atten_b | input | 7 | Channel B requested attenuation in dB |
| mute_a | input | 1 | Channel A mute request |
| mute_b | input | 1 | Channel B mute request |
| xfer_mode | input | 2 | 00 jump, 01 jump on zero crossing, 10 ramp, 11 ramp on zero crossing |
| link | input | 1 | Both channels follow channel A settings |
| amute_en | input | 1 | Enables silence-driven auto-mute |
| level_a | output | 10 | Channel A applied attenuation, eighth-dB units |
| level_b | output | 10 | Channel B applied attenuation, eighth-dB units |
| mute_ctl | output | 1 | High while both channels are muted |

## Verification
On every cycle the assertions check the following. The levels hold between strobes. A ramp-mode frame moves a level by at most one eighth-dB. An over-range code in jump mode lands on the mute level. Linked channels agree after a jump-mode frame. mute_ctl is high only when both levels are at mute. The bench scenarios are the only place the frame-to-frame history is exercised: the per-channel zero-crossing memory, the 512-frame timeout landing on exactly the right frame, the 8192-sample silence run and its release one frame later, and the independence of the two channels. The behavioural reference model compared on every clock covers these.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int SAMP_W     = 24;
  localparam int CODE_W     = 7;
  localparam int MAX_DB     = 94;
  localparam int SUB_STEPS  = 8;
  localparam int MUTE_LVL   = (MAX_DB + 1) * SUB_STEPS;
  localparam int LVL_W      = $clog2(MUTE_LVL + 1);
  localparam int TMO_FRAMES = 512;
  localparam int SIL_FRAMES = 8192;
  localparam int NCH        = 2;

  typedef enum logic [1:0] {
    XF_NOW     = 2'b00,
    XF_ZC      = 2'b01,
    XF_RAMP    = 2'b10,
    XF_RAMP_ZC = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/vol_target.sv
module vol_target #(
  parameter int CODE_W    = 7,
  parameter int MAX_DB    = 94,
  parameter int SUB_STEPS = 8,
  parameter int LVL_W     = 10
) (
  input  logic [CODE_W-1:0] code,
  input  logic              mute_req,
  input  logic              auto_mute,
  output logic [LVL_W-1:0]  target
);
  localparam int MUTE_LVL = (MAX_DB + 1) * SUB_STEPS;

  logic over_range;

  always_comb begin
    over_range = (int'(code) > MAX_DB);
    if (mute_req || auto_mute || over_range)
      target = LVL_W'(MUTE_LVL);
    else
      target = LVL_W'(code) * LVL_W'(SUB_STEPS);
  end
endmodule

// File: rtl/vol_zc_gate.sv
module vol_zc_gate #(
  parameter int SAMP_W     = 24,
  parameter int TMO_FRAMES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [SAMP_W-1:0] samp,
  input  logic              gated,
  input  logic              pending,
  output logic              step_ok
);
  localparam int CW = (TMO_FRAMES > 1) ? $clog2(TMO_FRAMES) : 1;

  logic          prev_sign_q, prev_sign_d;
  logic [CW-1:0] wait_q, wait_d;
  logic          crossing, expired;

  always_comb begin
    crossing    = (samp[SAMP_W-1] != prev_sign_q) || (samp == '0);
    expired     = (wait_q == CW'(TMO_FRAMES - 1));
    step_ok     = !gated || crossing || expired;
    prev_sign_d = prev_sign_q;
    wait_d      = wait_q;
    if (frame_stb) begin
      prev_sign_d = samp[SAMP_W-1];
      if (gated && pending && !(crossing || expired))
        wait_d = wait_q + CW'(1);
      else
        wait_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sign_q <= 1'b0;
      wait_q      <= '0;
    end else if (frame_stb) begin
      prev_sign_q <= prev_sign_d;
      wait_q      <= wait_d;
    end
  end
endmodule

// File: rtl/vol_silence.sv
module vol_silence #(
  parameter int SAMP_W     = 24,
  parameter int SIL_FRAMES = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [SAMP_W-1:0] samp,
  input  logic              enable,
  output logic              auto_mute
);
  localparam int SW = $clog2(SIL_FRAMES + 1);

  logic [SW-1:0] run_q, run_d;
  logic          silent, full;

  always_comb begin
    silent = (samp == '0) || (samp == '1);
    full   = (run_q == SW'(SIL_FRAMES));
    run_d  = run_q;
    if (frame_stb) begin
      if (!silent)   run_d = '0;
      else if (!full) run_d = run_q + SW'(1);
    end
    auto_mute = enable && full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (frame_stb) run_q <= run_d;
  end
endmodule

// File: rtl/vol_stepper.sv
module vol_stepper #(
  parameter int LVL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic             ramp,
  input  logic             step_ok,
  input  logic [LVL_W-1:0] target,
  output logic [LVL_W-1:0] level
);
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             move;

  always_comb begin
    move  = frame_stb && step_ok && (lvl_q != target);
    lvl_d = lvl_q;
    if (move) begin
      if (!ramp)               lvl_d = target;
      else if (lvl_q < target) lvl_d = lvl_q + LVL_W'(1);
      else                     lvl_d = lvl_q - LVL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lvl_q <= '0;
    else if (move) lvl_q <= lvl_d;
  end

  assign level = lvl_q;
endmodule

// File: rtl/stereo_vol_ramp.sv
module stereo_vol_ramp
  import vol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [SAMP_W-1:0] samp_a,
  input  logic [SAMP_W-1:0] samp_b,
  input  logic [CODE_W-1:0] atten_a,
  input  logic [CODE_W-1:0] atten_b,
  input  logic              mute_a,
  input  logic              mute_b,
  input  logic [1:0]        xfer_mode,
  input  logic              link,
  input  logic              amute_en,
  output logic [LVL_W-1:0]  level_a,
  output logic [LVL_W-1:0]  level_b,
  output logic              mute_ctl
);
  logic [NCH-1:0][CODE_W-1:0] code_sel;
  logic [NCH-1:0]             mute_sel;
  logic [NCH-1:0][SAMP_W-1:0] samp_ch;
  logic [NCH-1:0][LVL_W-1:0]  target;
  logic [NCH-1:0][LVL_W-1:0]  level;
  logic [NCH-1:0]             auto_mute, step_ok, pending, at_mute;
  xfer_mode_e                 mode;

  assign mode        = xfer_mode_e'(xfer_mode);
  assign code_sel[0] = atten_a;
  assign mute_sel[0] = mute_a;
  assign code_sel[1] = link ? atten_a : atten_b;
  assign mute_sel[1] = link ? mute_a  : mute_b;
  assign samp_ch[0]  = samp_a;
  assign samp_ch[1]  = samp_b;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    vol_silence #(.SAMP_W(SAMP_W), .SIL_FRAMES(SIL_FRAMES)) u_sil (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
      .samp(samp_ch[ch]), .enable(amute_en), .auto_mute(auto_mute[ch])
    );

    vol_target #(.CODE_W(CODE_W), .MAX_DB(MAX_DB), .SUB_STEPS(SUB_STEPS),
                 .LVL_W(LVL_W)) u_tgt (
      .code(code_sel[ch]), .mute_req(mute_sel[ch]),
      .auto_mute(auto_mute[ch]), .target(target[ch])
    );

    assign pending[ch] = (level[ch] != target[ch]);

    vol_zc_gate #(.SAMP_W(SAMP_W), .TMO_FRAMES(TMO_FRAMES)) u_zc (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
      .samp(samp_ch[ch]),
      .gated(mode == XF_ZC || mode == XF_RAMP_ZC),
      .pending(pending[ch]), .step_ok(step_ok[ch])
    );

    vol_stepper #(.LVL_W(LVL_W)) u_step (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
      .ramp(mode == XF_RAMP || mode == XF_RAMP_ZC),
      .step_ok(step_ok[ch]), .target(target[ch]), .level(level[ch])
    );

    assign at_mute[ch] = (level[ch] == LVL_W'(MUTE_LVL));
  end

  assign level_a  = level[0];
  assign level_b  = level[1];
  assign mute_ctl = &at_mute;
endmodule

// File: rtl/vol_ramp_chk.sv
module vol_ramp_chk
  import vol_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_stb,
  input logic [1:0]        xfer_mode,
  input logic              link,
  input logic              amute_en,
  input logic [CODE_W-1:0] atten_a,
  input logic [LVL_W-1:0]  level_a,
  input logic [LVL_W-1:0]  level_b,
  input logic              mute_ctl
);
  localparam logic [LVL_W-1:0] MUTE_V = LVL_W'(MUTE_LVL);

  // R4
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(level_a) && $stable(level_b));

  // R6
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && xfer_mode[1] |=>
      (level_a == $past(level_a)) || (level_a == $past(level_a) + 10'd1) ||
      (level_a + 10'd1 == $past(level_a)));

  // R3
  over_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && xfer_mode == 2'b00 && int'(atten_a) > MAX_DB |=> level_a == MUTE_V);

  // R9
  link_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && link && xfer_mode == 2'b00 && !amute_en |=> level_a == level_b);

  // R11
  mute_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute_ctl |-> level_a == MUTE_V && level_b == MUTE_V);

  // R2
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_a <= MUTE_V && level_b <= MUTE_V);
endmodule

bind stereo_vol_ramp vol_ramp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .xfer_mode(xfer_mode),
  .link(link), .amute_en(amute_en), .atten_a(atten_a),
  .level_a(level_a), .level_b(level_b), .mute_ctl(mute_ctl)
);

// File: tb/stereo_vol_ramp_bench.sv
module stereo_vol_ramp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_stb = 1'b0;
  logic [23:0] samp_a = '0, samp_b = '0;
  logic [6:0]  atten_a = '0, atten_b = '0;
  logic        mute_a = 1'b0, mute_b = 1'b0;
  logic [1:0]  xfer_mode = 2'b00;
  logic        link = 1'b0, amute_en = 1'b0;
  logic [9:0]  level_a, level_b;
  logic        mute_ctl;

  int checks = 0, fails = 0, cycles = 0;
  string stage = "R1";

  // reference state
  int m_lvl[2], m_tc[2], m_sil[2];
  bit m_prev[2];

  always #2 clk = ~clk;

  stereo_vol_ramp u_stereo_vol_ramp (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .samp_a(samp_a),
    .samp_b(samp_b), .atten_a(atten_a), .atten_b(atten_b), .mute_a(mute_a),
    .mute_b(mute_b), .xfer_mode(xfer_mode), .link(link), .amute_en(amute_en),
    .level_a(level_a), .level_b(level_b), .mute_ctl(mute_ctl)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_lvl[c] = 0; m_tc[c] = 0; m_sil[c] = 0; m_prev[c] = 0;
      end
    end else if (frame_stb) begin
      for (int c = 0; c < 2; c++) begin
        int code, tgt;
        bit mreq, am, zc, pend, ok;
        logic [23:0] s;
        s    = (c == 0) ? samp_a : samp_b;
        code = (c == 0 || link) ? int'(atten_a) : int'(atten_b);
        mreq = (c == 0 || link) ? mute_a : mute_b;
        am   = amute_en && (m_sil[c] >= 8192);
        tgt  = (mreq || am || code > 94) ? 760 : code * 8;
        zc   = (s[23] != m_prev[c]) || (s == 0);
        pend = (m_lvl[c] != tgt);
        ok   = !xfer_mode[0] || zc || (m_tc[c] == 511);
        if (pend && ok) begin
          if (!xfer_mode[1])      m_lvl[c] = tgt;
          else if (m_lvl[c] < tgt) m_lvl[c] = m_lvl[c] + 1;
          else                     m_lvl[c] = m_lvl[c] - 1;
        end
        m_tc[c]   = (xfer_mode[0] && pend && !ok) ? m_tc[c] + 1 : 0;
        m_prev[c] = s[23];
        if (s == 24'h000000 || s == 24'hFFFFFF)
          m_sil[c] = (m_sil[c] < 8192) ? m_sil[c] + 1 : 8192;
        else
          m_sil[c] = 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    check({stage, " model level_a"}, int'(level_a), m_lvl[0]);
    check({stage, " model level_b"}, int'(level_b), m_lvl[1]);
    check({stage, " model mute_ctl"}, int'(mute_ctl),
          int'(m_lvl[0] == 760 && m_lvl[1] == 760));
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      summary();
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic frame(input logic [23:0] sa, input logic [23:0] sb);
    samp_a = sa; samp_b = sb; frame_stb = 1'b1;
    @(negedge clk); frame_stb = 1'b0;
    @(negedge clk);
  endtask

  localparam logic [23:0] POS = 24'h000100;
  localparam logic [23:0] NEG = 24'hFFFF00;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset level_a", int'(level_a), 0);
    check("R1 reset mute_ctl", int'(mute_ctl), 0);
    rst_n = 1'b1;
    @(negedge clk);
    frame(POS, POS);
    check("R1 first frame level_b", int'(level_b), 0);

    stage = "R2";
    atten_a = 7'd10; atten_b = 7'd40;
    frame(POS, POS);
    check("R2 code 10", int'(level_a), 80);
    check("R2 code 40", int'(level_b), 320);
    stage = "R4";
    atten_a = 7'd20;
    repeat (3) @(negedge clk);
    check("R4 no strobe hold", int'(level_a), 80);

    stage = "R3";
    atten_a = 7'd100;
    frame(POS, POS);
    check("R3 over range mutes", int'(level_a), 760);
    atten_a = 7'd94;
    frame(POS, POS);
    check("R2 code 94 boundary", int'(level_a), 752);

    stage = "R11";
    mute_a = 1'b1; mute_b = 1'b1;
    frame(POS, POS);
    check("R11 both muted", int'(mute_ctl), 1);
    mute_a = 1'b0; mute_b = 1'b0; atten_a = 7'd10;
    frame(POS, POS);
    check("R11 unmuted", int'(mute_ctl), 0);
    check("R11 b back", int'(level_b), 320);

    stage = "R5";
    xfer_mode = 2'b01; atten_a = 7'd5;
    frame(POS, POS);
    check("R5 no crossing holds", int'(level_a), 80);
    frame(NEG, POS);
    check("R5 crossing applies", int'(level_a), 40);
    stage = "R12";
    atten_a = 7'd10; atten_b = 7'd20;
    frame(POS, POS);
    check("R12 a crosses", int'(level_a), 80);
    check("R12 b does not", int'(level_b), 320);

    stage = "R8";
    xfer_mode = 2'b00;
    frame(POS, POS);
    xfer_mode = 2'b01; atten_a = 7'd20;
    repeat (511) frame(POS, POS);
    check("R8 before timeout", int'(level_a), 80);
    frame(POS, POS);
    check("R8 timeout forces step", int'(level_a), 160);

    stage = "R6";
    xfer_mode = 2'b10; atten_a = 7'd0; atten_b = 7'd0;
    repeat (10) frame(POS, POS);
    check("R6 ramp ten steps", int'(level_a), 150);
    repeat (150) frame(POS, POS);
    check("R6 ramp reaches 0", int'(level_b), 0);
    frame(POS, POS);
    check("R6 ramp holds at target", int'(level_a), 0);
    atten_a = 7'd1;
    repeat (3) frame(POS, POS);
    check("R6 ramp upward", int'(level_a), 3);

    stage = "R7";
    xfer_mode = 2'b11; atten_a = 7'd3;
    frame(POS, POS);
    check("R7 no crossing no step", int'(level_a), 3);
    frame(NEG, POS); frame(POS, POS); frame(NEG, POS); frame(POS, POS);
    check("R7 four crossing steps", int'(level_a), 7);

    stage = "R9";
    xfer_mode = 2'b00; link = 1'b1;
    atten_a = 7'd30; atten_b = 7'd50; mute_b = 1'b1;
    frame(POS, POS);
    check("R9 b follows a", int'(level_b), 240);
    link = 1'b0; mute_b = 1'b0; atten_a = 7'd0; atten_b = 7'd0;
    frame(POS, POS);

    stage = "R10";
    amute_en = 1'b1;
    repeat (8192) frame(24'h000000, 24'hFFFFFF);
    check("R10 not yet muted", int'(level_a), 0);
    frame(24'h000000, 24'hFFFFFF);
    check("R10 a auto muted", int'(level_a), 760);
    check("R10 b auto muted", int'(level_b), 760);
    check("R11 auto mute both", int'(mute_ctl), 1);
    frame(24'h000005, 24'hFFFFFF);
    check("R10 release lags a frame", int'(level_a), 760);
    frame(24'h000005, 24'hFFFFFF);
    check("R10 released", int'(level_a), 0);
    check("R12 b stays muted", int'(level_b), 760);
    check("R11 drops", int'(mute_ctl), 0);

    summary();
  end
endmodule